// File: doc/BRIEF.md
# Two-Slot Instruction Decoder

This block sits behind the fetch stage of a register-based virtual machine core. It takes one 64-bit instruction word per accepted handshake and splits it into its fields. It then hands one decoded record per architectural instruction to the execute stage. The record holds the opcode, the class, the operation nibble, the source-operand selector, both register numbers, the offset, a 64-bit immediate, a wide marker and an illegal flag.

Every instruction but one fits in a single slot. The exception is the wide constant load (opcode byte 0x18). It occupies two consecutive slots. The decoder holds the first slot and emits nothing for it. It then builds the 64-bit constant from the immediate fields of both slots and checks that the second slot is a clean pseudo-instruction. Fetch addressing, execution, branching and memory access are left to the surrounding pipeline.

Top module: `wide_insn_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and no wide instruction is pending, so the first accepted word is decoded as the start of a new instruction.
- R2: For a single-slot word accepted in cycle N, `out_valid` is 1 in cycle N+1. The fields are taken as opcode = bits 7:0, destination = bits 11:8, source = bits 15:12, offset = bits 31:16 and immediate = bits 63:32.
- R3: For a single-slot word, `out_imm` is the 32-bit immediate sign-extended to 64 bits, and `out_wide` is 0.
- R4: `out_class` is opcode bits 2:0 and `out_alu_op` is opcode bits 7:4. `out_src_is_reg` equals opcode bit 3 when the class is 4 to 7 (arithmetic and jump classes) and is 0 for classes 0 to 3.
- R5: `out_illegal` is 1 when the destination number exceeds 10, or when the source number exceeds 10. The source field of the first slot of a wide load is exempt from this range check.
- R6: A word with opcode 0x18 produces no record when accepted. The record appears in the cycle after the following word is accepted. It carries `out_wide` = 1 and the opcode, registers and offset of the first slot.
- R7: The wide constant is (second-slot immediate << 32) | first-slot immediate. The first-slot immediate is not sign-extended.
- R8: If bits 31:0 of the second slot (opcode, destination, source, offset) are not all zero, the wide record has `out_illegal` = 1.
- R9: Cycles with `in_valid` low between the two slots keep the pending first slot and produce no record. A reset while a first slot is pending discards it.
- R10: `in_ready` is 1 in every cycle after reset is released. With `in_valid` low, no record is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 64 | Instruction word |
| out_valid | output | 1 | Decoded record present this cycle |
| out_opcode | output | 8 | Opcode byte |
| out_class | output | 3 | Instruction class |
| out_alu_op | output | 4 | Operation nibble |
| out_src_is_reg | output | 1 | Second operand comes from the source register |
| out_dst | output | 4 | Destination register number |
| out_src | output | 4 | Source register number |
| out_offset | output | 16 | Signed offset |
| out_imm | output | 64 | Immediate, sign-extended or wide constant |
| out_wide | output | 1 | Record came from a two-slot load |
| out_illegal | output | 1 | Encoding violation detected |

## Verification
A single-slot record is due exactly one cycle after its word is accepted. A wide record is due one cycle after its second slot is accepted. The first slot and idle cycles must leave `out_valid` low in the following cycle. The bench drives each word on a falling edge and lets one rising edge pass. It compares the registered outputs on the next falling edge against a behavioural model that tracks the pending first slot. Every clock is therefore checked at the cycle where the result is due, including the silent ones.

// File: rtl/insn_dec_pkg.sv
`timescale 1ns/1ps
package insn_dec_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned IMM_W  = 32;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned CLS_W  = 3;

  typedef struct packed {
    logic [IMM_W-1:0] imm32;
    logic [OFF_W-1:0] offset;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [OP_W-1:0]  opcode;
  } insn_fields_t;

  typedef struct packed {
    logic [OP_W-1:0]   opcode;
    logic [CLS_W-1:0]  cls;
    logic [3:0]        alu_op;
    logic              src_is_reg;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src;
    logic [OFF_W-1:0]  offset;
    logic [WORD_W-1:0] imm;
    logic              wide;
    logic              illegal;
  } dec_rec_t;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] join_wide(input logic [IMM_W-1:0] lo,
                                                  input logic [IMM_W-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic pseudo_clean(input insn_fields_t f);
    return (f.opcode == '0) && (f.dst == '0) && (f.src == '0) && (f.offset == '0);
  endfunction

  function automatic dec_rec_t make_rec(input insn_fields_t f, input logic [WORD_W-1:0] imm,
                                        input logic wide, input logic illegal);
    dec_rec_t r;
    r.opcode     = f.opcode;
    r.cls        = f.opcode[CLS_W-1:0];
    r.alu_op     = f.opcode[OP_W-1:4];
    r.src_is_reg = f.opcode[CLS_W-1] & f.opcode[3];
    r.dst        = f.dst;
    r.src        = f.src;
    r.offset     = f.offset;
    r.imm        = imm;
    r.wide       = wide;
    r.illegal    = illegal;
    return r;
  endfunction
endpackage

// File: rtl/insn_field_split.sv
`timescale 1ns/1ps
module insn_field_split
  import insn_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output insn_fields_t      fields_o
);
  always_comb begin
    fields_o.opcode = word_i[OP_W-1:0];
    fields_o.dst    = word_i[OP_W+REG_W-1:OP_W];
    fields_o.src    = word_i[OP_W+2*REG_W-1:OP_W+REG_W];
    fields_o.offset = word_i[IMM_W-1:OP_W+2*REG_W];
    fields_o.imm32  = word_i[WORD_W-1:IMM_W];
  end
endmodule

// File: rtl/insn_legal_check.sv
`timescale 1ns/1ps
module insn_legal_check
  import insn_dec_pkg::*;
#(
  parameter int unsigned MAX_REG = 10
) (
  input  insn_fields_t fields_i,
  input  logic         src_exempt_i,
  output logic         dst_bad_o,
  output logic         src_bad_o,
  output logic         reg_bad_o
);
  localparam logic [REG_W-1:0] LIMIT = REG_W'(MAX_REG);

  always_comb begin
    dst_bad_o = fields_i.dst > LIMIT;
    src_bad_o = (fields_i.src > LIMIT) && !src_exempt_i;
    reg_bad_o = dst_bad_o | src_bad_o;
  end
endmodule

// File: rtl/wide_insn_decoder.sv
`timescale 1ns/1ps
module wide_insn_decoder
  import insn_dec_pkg::*;
#(
  parameter int unsigned    MAX_REG = 10,
  parameter logic [7:0]     WIDE_OP = 8'h18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_word,
  output logic        out_valid,
  output logic [7:0]  out_opcode,
  output logic [2:0]  out_class,
  output logic [3:0]  out_alu_op,
  output logic        out_src_is_reg,
  output logic [3:0]  out_dst,
  output logic [3:0]  out_src,
  output logic [15:0] out_offset,
  output logic [63:0] out_imm,
  output logic        out_wide,
  output logic        out_illegal
);
  typedef enum logic {SLOT_IDLE, SLOT_WAIT_HI} slot_state_e;

  slot_state_e  state_q;
  insn_fields_t cur_fields;
  insn_fields_t held_q;
  logic         held_bad_q;
  logic         ready_q;
  dec_rec_t     rec_d, rec_q;
  logic         valid_q;

  // Named events for the assertions below
  logic in_fire, pending, is_wide_op;
  logic take_basic, take_first, take_second;
  logic cur_dst_bad, cur_src_bad, cur_reg_bad, second_dirty;

  insn_field_split u_split (
    .word_i   (in_word),
    .fields_o (cur_fields)
  );

  assign pending    = (state_q == SLOT_WAIT_HI);
  assign is_wide_op = (cur_fields.opcode == WIDE_OP);

  insn_legal_check #(.MAX_REG(MAX_REG)) u_check (
    .fields_i     (cur_fields),
    .src_exempt_i (is_wide_op && !pending),
    .dst_bad_o    (cur_dst_bad),
    .src_bad_o    (cur_src_bad),
    .reg_bad_o    (cur_reg_bad)
  );

  assign in_ready     = ready_q;
  assign in_fire      = in_valid && ready_q;
  assign take_basic   = in_fire && !pending && !is_wide_op;
  assign take_first   = in_fire && !pending && is_wide_op;
  assign take_second  = in_fire && pending;
  assign second_dirty = !pseudo_clean(cur_fields);

  always_comb begin
    if (pending)
      rec_d = make_rec(held_q, join_wide(held_q.imm32, cur_fields.imm32), 1'b1,
                       held_bad_q | second_dirty);
    else
      rec_d = make_rec(cur_fields, sext_imm(cur_fields.imm32), 1'b0, cur_reg_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      state_q    <= SLOT_IDLE;
      held_q     <= '0;
      held_bad_q <= 1'b0;
      valid_q    <= 1'b0;
      rec_q      <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= take_basic | take_second;
      if (take_basic | take_second)
        rec_q <= rec_d;
      if (take_first) begin
        state_q    <= SLOT_WAIT_HI;
        held_q     <= cur_fields;
        held_bad_q <= cur_reg_bad;
      end else if (take_second) begin
        state_q <= SLOT_IDLE;
      end
    end
  end

  assign out_valid      = valid_q;
  assign out_opcode     = rec_q.opcode;
  assign out_class      = rec_q.cls;
  assign out_alu_op     = rec_q.alu_op;
  assign out_src_is_reg = rec_q.src_is_reg;
  assign out_dst        = rec_q.dst;
  assign out_src        = rec_q.src;
  assign out_offset     = rec_q.offset;
  assign out_imm        = rec_q.imm;
  assign out_wide       = rec_q.wide;
  assign out_illegal    = rec_q.illegal;

  assert_basic_emits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_basic |=> (out_valid && !out_wide));

  assert_range_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_basic && (in_word[11:8] > 4'(MAX_REG))) |=> out_illegal);

  assert_first_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_first |=> (!out_valid && pending));

  assert_second_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_second |=> (out_valid && out_wide && !pending));

  assert_high_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_second |=> (out_imm[63:32] == $past(in_word[63:32])));

  assert_dirty_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_second && (in_word[31:0] != 32'h0)) |=> out_illegal);

  assert_gap_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !in_valid) |=> (pending && !out_valid));

  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> !out_valid);
endmodule

// File: tb/wide_insn_decoder_tb_top.sv
`timescale 1ns/1ps
module wide_insn_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic        in_ready, out_valid, out_src_is_reg, out_wide, out_illegal;
  logic [7:0]  out_opcode;
  logic [2:0]  out_class;
  logic [3:0]  out_alu_op, out_dst, out_src;
  logic [15:0] out_offset;
  logic [63:0] out_imm;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Reference model state
  bit          m_pend = 1'b0;
  logic [63:0] m_first = '0;

  always #10 clk = ~clk;

  wide_insn_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_opcode(out_opcode), .out_class(out_class),
    .out_alu_op(out_alu_op), .out_src_is_reg(out_src_is_reg), .out_dst(out_dst),
    .out_src(out_src), .out_offset(out_offset), .out_imm(out_imm), .out_wide(out_wide),
    .out_illegal(out_illegal)
  );

  function automatic logic [63:0] mk(input logic [31:0] imm, input logic [15:0] off,
                                     input logic [3:0] src, input logic [3:0] dst,
                                     input logic [7:0] op);
    return {imm, off, src, dst, op};
  endfunction

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    m_pend   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drive one cycle at a falling edge, compare at the next falling edge.
  task automatic step(input logic v, input logic [63:0] w, input string tag);
    logic e_valid, e_sreg, e_wide, e_ill;
    logic [7:0] e_op; logic [3:0] e_dst, e_src; logic [15:0] e_off; logic [63:0] e_imm;
    logic [63:0] src_w;
    int unsigned d, s;
    e_valid = 1'b0; e_sreg = 1'b0; e_wide = 1'b0; e_ill = 1'b0;
    e_op = '0; e_dst = '0; e_src = '0; e_off = '0; e_imm = '0;
    in_valid = v;
    in_word  = w;
    if (v) begin
      if (!m_pend && w[7:0] == 8'h18) begin
        m_pend  = 1'b1;
        m_first = w;
      end else begin
        src_w   = m_pend ? m_first : w;
        e_valid = 1'b1;
        e_op    = src_w[7:0];
        e_dst   = src_w[11:8];
        e_src   = src_w[15:12];
        e_off   = src_w[31:16];
        e_sreg  = (int'(src_w[2:0]) >= 4) ? src_w[3] : 1'b0;
        d = e_dst; s = e_src;
        if (m_pend) begin
          e_wide = 1'b1;
          e_imm  = (64'(w[63:32]) << 32) | 64'(src_w[63:32]);
          e_ill  = (d > 10) || (w[31:0] != 32'h0);
          m_pend = 1'b0;
        end else begin
          e_imm = 64'($signed(src_w[63:32]));
          e_ill = (d > 10) || (s > 10);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== e_valid ||
        (e_valid && (out_opcode !== e_op || out_class !== e_op[2:0] || out_alu_op !== e_op[7:4] ||
                     out_src_is_reg !== e_sreg || out_dst !== e_dst || out_src !== e_src ||
                     out_offset !== e_off || out_imm !== e_imm || out_wide !== e_wide ||
                     out_illegal !== e_ill))) begin
      fails++;
      $display("FAIL %s: actual v=%0b op=%h cls=%0d aop=%h sreg=%0b d=%0d s=%0d off=%h imm=%h w=%0b ill=%0b expected v=%0b op=%h cls=%0d aop=%h sreg=%0b d=%0d s=%0d off=%h imm=%h w=%0b ill=%0b",
               tag, out_valid, out_opcode, out_class, out_alu_op, out_src_is_reg, out_dst, out_src,
               out_offset, out_imm, out_wide, out_illegal,
               e_valid, e_op, e_op[2:0], e_op[7:4], e_sreg, e_dst, e_src, e_off, e_imm, e_wide, e_ill);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    do_reset();
    // R1 / R10: reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: actual valid=%0b ready=%0b expected valid=0 ready=1", out_valid, in_ready);
    end
    step(1'b0, '0, "R10 idle");
    // R2 R4: register-source arithmetic, 64-bit class
    step(1'b1, mk(32'h0000_0005, 16'h0000, 4'd2, 4'd1, 8'h0f), "R2 R4 alu64 reg");
    // R3: negative immediate sign-extended
    step(1'b1, mk(32'hFFFF_FFF0, 16'h0000, 4'd0, 4'd3, 8'h04), "R3 sext imm");
    // R4: jump class with register source, negative offset
    step(1'b1, mk(32'h0000_0000, 16'hFFFE, 4'd4, 4'd5, 8'h1d), "R4 jmp reg");
    // R4: load class with bit 3 set is not a source selector
    step(1'b1, mk(32'h0000_0000, 16'h0010, 4'd6, 4'd7, 8'h79), "R4 ldx no sel");
    // R5: range boundaries
    step(1'b1, mk(32'h1, 16'h0, 4'd10, 4'd10, 8'h07), "R5 reg 10 legal");
    step(1'b1, mk(32'h1, 16'h0, 4'd0, 4'd11, 8'h07), "R5 dst 11");
    step(1'b1, mk(32'h1, 16'h0, 4'd15, 4'd0, 8'h0f), "R5 src 15");
    // R6 R7: wide load, low half with top bit set stays unextended
    step(1'b1, mk(32'h8000_0000, 16'h0, 4'd0, 4'd2, 8'h18), "R6 first slot silent");
    step(1'b1, mk(32'h0000_0001, 16'h0, 4'd0, 4'd0, 8'h00), "R7 wide constant");
    // R5: src field of first wide slot exempt; R9: gaps while pending
    step(1'b1, mk(32'h1234_5678, 16'h0, 4'd15, 4'd9, 8'h18), "R5 R6 wide src exempt");
    step(1'b0, '0, "R9 gap");
    step(1'b0, '0, "R9 gap");
    step(1'b1, mk(32'hDEAD_BEEF, 16'h0, 4'd0, 4'd0, 8'h00), "R9 R7 wide after gap");
    // R8: dirty second slot
    step(1'b1, mk(32'h0, 16'h0, 4'd0, 4'd1, 8'h18), "R6 first");
    step(1'b1, mk(32'h5, 16'h0004, 4'd0, 4'd0, 8'h00), "R8 offset dirty");
    step(1'b1, mk(32'h0, 16'h0, 4'd0, 4'd1, 8'h18), "R6 first");
    step(1'b1, mk(32'h5, 16'h0, 4'd0, 4'd0, 8'h07), "R8 opcode dirty");
    step(1'b1, mk(32'h0, 16'h0, 4'd0, 4'd12, 8'h18), "R6 first dst bad");
    step(1'b1, mk(32'h0, 16'h0, 4'd0, 4'd0, 8'h00), "R5 wide dst 12");
    // Back-to-back wide loads
    step(1'b1, mk(32'hCAFE_0001, 16'h0, 4'd0, 4'd3, 8'h18), "R6 first");
    step(1'b1, mk(32'h7FFF_FFFF, 16'h0, 4'd0, 4'd0, 8'h00), "R7 wide b2b");
    step(1'b1, mk(32'h11, 16'h0, 4'd0, 4'd4, 8'h18), "R6 first");
    step(1'b1, mk(32'h22, 16'h0, 4'd0, 4'd0, 8'h00), "R7 wide b2b 2");
    // R9: reset discards a pending first slot
    step(1'b1, mk(32'hAAAA_AAAA, 16'h0, 4'd0, 4'd6, 8'h18), "R6 first before reset");
    do_reset();
    step(1'b1, mk(32'h0000_0042, 16'h0, 4'd1, 4'd2, 8'h0c), "R9 reset clears pending");
    step(1'b0, '0, "R10 idle after");
    // R1: a word with opcode 0x18 after reset starts a new wide load
    step(1'b1, mk(32'h3, 16'h0, 4'd0, 4'd0, 8'h18), "R1 fresh first");
    step(1'b1, mk(32'h4, 16'h0, 4'd0, 4'd0, 8'h00), "R1 R7 fresh wide");
    done = 1'b1;
    summary();
  end
endmodule